// File: doc/BRIEF.md
# Byte-Wide Indirect Register Bridge

This block lets a host on a 32-bit memory-mapped port reach a byte-addressed, byte-wide register store inside a consumer-electronics control controller. Every access to the store passes through a single packed command word. The host writes an address, an optional data byte and a direction flag into that word. It then polls a busy flag in the same word. When the flag drops, a read's result appears in the top byte of the word. One byte moves per request.

A fixed multi-cycle latency stands in for the slower internal clock. During that time the internal store is reached through a request/acknowledge handshake.

Alongside the command word the bridge keeps three more host registers:
- a general control register that drives a soft-reset line and a two-bit clock-mode field;
- a small interrupt group with an enable mask, a write-one-to-clear register and a sticky raw status;
- the status register collects two event inputs, transmit done and receive done, and the block raises one interrupt line from them.

Top module: `cec_regbridge`

## Requirements
- R1: After reset, the control word (offset 0x00), command word (0x04), mask (0x08) and status (0x10) all read 0, and `irq` is low.
- R2: The command word at offset 0x04 reads as: bits 7:0 the latched address, bits 15:8 the latched write byte, bit 16 the latched write flag, bit 23 busy, bits 31:24 the last read result, and all other bits 0.
- R3: Writing offset 0x04 with bit 16 set stores bits 15:8 at the address in bits 7:0. Writing it with bit 16 clear reads that address. The byte appears in bits 31:24 once busy has cleared.
- R4: Busy rises in the cycle after an accepted command write and stays high for exactly LAT cycles (default 4).
- R5: A write to offset 0x04 while busy is high has no effect: the latched fields and the store stay unchanged.
- R6: The read-result field keeps its value until the next read completes; completion of a write leaves it unchanged.
- R7: Mask register at 0x08: bit 1 enables the transmit source and bit 2 the receive source (1 = enabled); other bits read 0. `irq` is high exactly when a status bit and its mask bit are both set.
- R8: Status register at 0x10: bit 1 is set by a pulse on `ev_tx_done` and bit 2 by a pulse on `ev_rx_done`. Both stay set until cleared; other bits read 0.
- R9: Writing 1 to bit 1 or bit 2 of offset 0x0C clears that status bit. If an event sets the same bit in the same cycle, the bit stays set.
- R10: Control register at 0x00: bit 0 drives `ctl_soft_reset` and bits 2:1 drive `ctl_clk_mode` (0 off, 1 on, 2 on for debug). These three bits read back and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| ev_tx_done | input | 1 | Transmit-complete event pulse |
| ev_rx_done | input | 1 | Receive-complete event pulse |
| irq | output | 1 | Combined, masked interrupt |
| ctl_soft_reset | output | 1 | Soft-reset bit of the control word |
| ctl_clk_mode | output | 2 | Clock-mode field of the control word |

## Verification
Two pairs of actions can land on the same edge.

The first pair is an event pulse and a write-one-to-clear of the same status bit. The bench drives `ev_tx_done` and a clear of bit 1 in one cycle and requires the bit to read set afterwards.

The second pair is a new command word and an access still in flight. The bench issues a second write command two cycles into the first. The latched address must stay that of the first command, and reading back the second command's target must return its earlier contents.

// File: rtl/cec_rb_pkg.sv
package cec_rb_pkg;

   // host register offsets
   localparam logic [7:0] OFS_CTL  = 8'h00;
   localparam logic [7:0] OFS_CMD  = 8'h04;
   localparam logic [7:0] OFS_MASK = 8'h08;
   localparam logic [7:0] OFS_CLR  = 8'h0C;
   localparam logic [7:0] OFS_STAT = 8'h10;

   // interrupt source positions
   localparam int IRQ_W      = 3;
   localparam int IRQ_TX_POS = 1;
   localparam int IRQ_RX_POS = 2;
   localparam logic [IRQ_W-1:0] IRQ_VALID = 3'b110;

   // packed command word, most significant field first
   typedef struct packed {
      logic [7:0] rd_byte;
      logic       busy;
      logic [5:0] rsvd;
      logic       wr_flag;
      logic [7:0] wr_byte;
      logic [7:0] addr;
   } cmd_word_t;

endpackage

// File: rtl/cec_rb_store.sv
module cec_rb_store #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter bit CLR_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ack,
   output logic [DATA_W-1:0] ack_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack       <= 1'b0;
         ack_rdata <= '0;
      end else begin
         ack <= req;
         if (req && !req_wr) ack_rdata <= mem[req_addr];
      end
   end

   generate
      if (CLR_INIT) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (req && req_wr) begin
               mem[req_addr] <= req_wdata;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (req && req_wr) mem[req_addr] <= req_wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/cec_rb_cmd.sv
module cec_rb_cmd #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int LAT    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic              cmd_we,
   output logic              busy,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] byte_q,
   output logic              we_q,
   output logic [DATA_W-1:0] rd_q,
   output logic              st_req,
   input  logic              st_ack,
   input  logic [DATA_W-1:0] st_rdata
);
   localparam int CW = $clog2(LAT + 1);

   logic [CW-1:0] cnt;

   // request one cycle before the handshake finishes the window
   assign st_req = busy && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         addr_q <= '0;
         byte_q <= '0;
         we_q   <= 1'b0;
         rd_q   <= '0;
      end else if (cmd_wr && !busy) begin
         busy   <= 1'b1;
         cnt    <= CW'(LAT - 1);
         addr_q <= cmd_addr;
         byte_q <= cmd_byte;
         we_q   <= cmd_we;
      end else if (busy) begin
         if (cnt != '0) cnt <= cnt - CW'(1);
         if (st_ack) begin
            busy <= 1'b0;
            if (!we_q) rd_q <= st_rdata;
         end
      end
   end

endmodule

// File: rtl/cec_rb_irq.sv
module cec_rb_irq
   import cec_rb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_tx,
   input  logic             ev_rx,
   input  logic             mask_wr,
   input  logic             clr_wr,
   input  logic [IRQ_W-1:0] wbits,
   output logic [IRQ_W-1:0] mask_q,
   output logic [IRQ_W-1:0] stat_q,
   output logic             irq
);
   logic [IRQ_W-1:0] set_v;
   logic [IRQ_W-1:0] clr_v;

   always_comb begin
      set_v             = '0;
      set_v[IRQ_TX_POS] = ev_tx;
      set_v[IRQ_RX_POS] = ev_rx;
      clr_v             = clr_wr ? (wbits & IRQ_VALID) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (mask_wr) mask_q <= wbits & IRQ_VALID;
         stat_q <= (stat_q & ~clr_v) | set_v;
      end
   end

   assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/cec_regbridge.sv
module cec_regbridge
   import cec_rb_pkg::*;
#(
   parameter int HOST_AW  = 8,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int LAT      = 4,
   parameter bit CLR_INIT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   input  logic               ev_tx_done,
   input  logic               ev_rx_done,
   output logic               irq,
   output logic               ctl_soft_reset,
   output logic [1:0]         ctl_clk_mode
);
   generate
      if (LAT < 2) begin : g_bad_lat
         $error("cec_regbridge: LAT must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_aw
         $error("cec_regbridge: ADDR_W must be 1..8");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("cec_regbridge: DATA_W must be 8 for the packed word");
      end
      if (HOST_AW < 5) begin : g_bad_haw
         $error("cec_regbridge: HOST_AW must reach offset 0x10");
      end
   endgenerate

   logic ctl_hit, cmd_hit, mask_hit, clr_hit;

   assign ctl_hit  = host_wr && (host_addr == HOST_AW'(OFS_CTL));
   assign cmd_hit  = host_wr && (host_addr == HOST_AW'(OFS_CMD));
   assign mask_hit = host_wr && (host_addr == HOST_AW'(OFS_MASK));
   assign clr_hit  = host_wr && (host_addr == HOST_AW'(OFS_CLR));

   // general control word
   logic [2:0] ctl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl_q <= '0;
      else if (ctl_hit) ctl_q <= host_wdata[2:0];
   end
   assign ctl_soft_reset = ctl_q[0];
   assign ctl_clk_mode   = ctl_q[2:1];

   // command engine and internal store
   logic              cmd_busy, we_field, st_req, st_ack;
   logic [ADDR_W-1:0] addr_field;
   logic [DATA_W-1:0] byte_field, rd_field, st_rdata;

   cec_rb_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_hit),
      .cmd_addr (host_wdata[ADDR_W-1:0]),
      .cmd_byte (host_wdata[15:8]),
      .cmd_we   (host_wdata[16]),
      .busy     (cmd_busy),
      .addr_q   (addr_field),
      .byte_q   (byte_field),
      .we_q     (we_field),
      .rd_q     (rd_field),
      .st_req   (st_req),
      .st_ack   (st_ack),
      .st_rdata (st_rdata)
   );

   cec_rb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_INIT(CLR_INIT)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (st_req),
      .req_wr    (we_field),
      .req_addr  (addr_field),
      .req_wdata (byte_field),
      .ack       (st_ack),
      .ack_rdata (st_rdata)
   );

   // interrupt group
   logic [IRQ_W-1:0] mask_q, stat_q;

   cec_rb_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_tx   (ev_tx_done),
      .ev_rx   (ev_rx_done),
      .mask_wr (mask_hit),
      .clr_wr  (clr_hit),
      .wbits   (host_wdata[IRQ_W-1:0]),
      .mask_q  (mask_q),
      .stat_q  (stat_q),
      .irq     (irq)
   );

   // host read mux
   cmd_word_t cmd_view;
   always_comb begin
      cmd_view         = '0;
      cmd_view.rd_byte = rd_field;
      cmd_view.busy    = cmd_busy;
      cmd_view.wr_flag = we_field;
      cmd_view.wr_byte = byte_field;
      cmd_view.addr    = 8'(addr_field);
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == HOST_AW'(OFS_CTL))       host_rdata = {29'b0, ctl_q};
      else if (host_addr == HOST_AW'(OFS_CMD))  host_rdata = cmd_view;
      else if (host_addr == HOST_AW'(OFS_MASK)) host_rdata = {{(32-IRQ_W){1'b0}}, mask_q};
      else if (host_addr == HOST_AW'(OFS_STAT)) host_rdata = {{(32-IRQ_W){1'b0}}, stat_q};
   end

endmodule

// File: rtl/cec_rb_chk.sv
module cec_rb_chk #(
   parameter int ADDR_W = 8,
   parameter int LAT    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              cmd_hit,
   input logic              clr_hit,
   input logic [31:0]       host_wdata,
   input logic [ADDR_W-1:0] addr_field,
   input logic              we_field,
   input logic [7:0]        rd_field,
   input logic              ev_tx,
   input logic [2:0]        stat
);
   localparam int RW = $clog2(LAT + 2);

   logic [RW-1:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + RW'(1);
      else           run <= '0;
   end

   p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_hit));

   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == RW'(LAT)));

   p_busy_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RW'(LAT));

   p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_hit) |=> $stable(addr_field));

   p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && we_field) |-> $stable(rd_field));

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx |=> stat[1]);

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && host_wdata[1] && !ev_tx) |=> !stat[1]);

endmodule

bind cec_regbridge cec_rb_chk #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (cmd_busy),
   .cmd_hit    (cmd_hit),
   .clr_hit    (clr_hit),
   .host_wdata (host_wdata),
   .addr_field (addr_field),
   .we_field   (we_field),
   .rd_field   (rd_field),
   .ev_tx      (ev_tx_done),
   .stat       (stat_q)
);

// File: tb/cec_regbridge_tb.sv
module cec_regbridge_tb_top;
   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        ev_tx_done = 1'b0;
   logic        ev_rx_done = 1'b0;
   logic        irq, ctl_soft_reset;
   logic [1:0]  ctl_clk_mode;

   always #5 clk = ~clk;

   cec_regbridge #(.LAT(LAT)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .host_wr        (host_wr),
      .host_addr      (host_addr),
      .host_wdata     (host_wdata),
      .host_rdata     (host_rdata),
      .ev_tx_done     (ev_tx_done),
      .ev_rx_done     (ev_rx_done),
      .irq            (irq),
      .ctl_soft_reset (ctl_soft_reset),
      .ctl_clk_mode   (ctl_clk_mode)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) ^ 8'hA5);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr  = a;
      host_wdata = d;
      host_wr    = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      peek(8'h04, d);
      while (d[23]) begin
         @(negedge clk);
         peek(8'h04, d);
      end
   endtask

   task automatic st_write(input logic [7:0] a, input logic [7:0] b);
      wait_idle();
      wr(8'h04, {15'h0, 1'b1, b, a});
      wait_idle();
   endtask

   task automatic st_read(input logic [7:0] a, output logic [7:0] b);
      logic [31:0] d;
      wait_idle();
      wr(8'h04, {16'h0, 8'h00, a});
      wait_idle();
      peek(8'h04, d);
      b = d[31:24];
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_bad++;
         $display("FAIL watchdog R4 act=busy-hung exp=idle");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;
      int          n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(8'h00, d); chk("R1 ctl", d, 32'h0);
      peek(8'h04, d); chk("R1 cmd", d, 32'h0);
      peek(8'h08, d); chk("R1 mask", d, 32'h0);
      peek(8'h10, d); chk("R1 stat", d, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R10 control word sweep
      for (int v = 0; v < 8; v++) begin
         wr(8'h00, 32'hFFFF_FFF8 | 32'(v));
         peek(8'h00, d);
         chk("R10 readback", d, 32'(v));
         chk("R10 outputs", {29'h0, ctl_clk_mode, ctl_soft_reset}, 32'(v));
      end

      // R3 full store sweep
      for (int a = 0; a < 256; a++) st_write(8'(a), pat(a));
      for (int a = 0; a < 256; a++) begin
         st_read(8'(a), b);
         chk("R3 byte", {24'h0, b}, {24'h0, pat(a)});
      end

      // R2 layout and R6 hold after a write completes
      st_write(8'h3C, 8'h96);
      peek(8'h04, d);
      chk("R2 layout", d, {pat(255), 1'b0, 6'h0, 1'b1, 8'h96, 8'h3C});
      chk("R6 hold", {24'h0, d[31:24]}, {24'h0, pat(255)});

      // R4 busy length
      wait_idle();
      wr(8'h04, {16'h0, 8'h00, 8'h05});
      n = 0;
      peek(8'h04, d);
      while (d[23] && n < 100) begin
         n++;
         @(negedge clk);
         peek(8'h04, d);
      end
      chk("R4 busy cycles", 32'(n), 32'(LAT));
      chk("R3 read 05", {24'h0, d[31:24]}, {24'h0, pat(5)});

      // R5 command while busy is ignored
      wait_idle();
      wr(8'h04, {15'h0, 1'b1, 8'h11, 8'h0A});
      wr(8'h04, {15'h0, 1'b1, 8'h77, 8'h14});
      peek(8'h04, d);
      chk("R5 addr kept", {24'h0, d[7:0]}, 32'h0A);
      chk("R5 byte kept", {24'h0, d[15:8]}, 32'h11);
      st_read(8'h14, b);
      chk("R5 store untouched", {24'h0, b}, {24'h0, pat(20)});
      st_read(8'h0A, b);
      chk("R3 first write", {24'h0, b}, 32'h11);

      // R7 R8 mask/event sweep
      for (int m = 0; m < 4; m++) begin
         for (int e = 0; e < 4; e++) begin
            wr(8'h0C, 32'h6);
            wr(8'h08, 32'hFFFF_FFF9 | 32'(m << 1));
            peek(8'h08, d);
            chk("R7 mask readback", d, 32'(m << 1));
            @(negedge clk);
            ev_tx_done = e[0];
            ev_rx_done = e[1];
            @(negedge clk);
            ev_tx_done = 1'b0;
            ev_rx_done = 1'b0;
            repeat (2) @(negedge clk);
            peek(8'h10, d);
            chk("R8 status", d, 32'(e << 1));
            chk("R7 irq", {31'h0, irq}, {31'h0, (e & m) != 0});
         end
      end

      // R9 clear one bit, keep the other
      wr(8'h0C, 32'h6);
      @(negedge clk);
      ev_tx_done = 1'b1;
      ev_rx_done = 1'b1;
      @(negedge clk);
      ev_tx_done = 1'b0;
      ev_rx_done = 1'b0;
      wr(8'h0C, 32'h2);
      peek(8'h10, d);
      chk("R9 clear bit1", d, 32'h4);

      // R9 set and clear in the same cycle
      @(negedge clk);
      host_addr  = 8'h0C;
      host_wdata = 32'h2;
      host_wr    = 1'b1;
      ev_tx_done = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
      ev_tx_done = 1'b0;
      peek(8'h10, d);
      chk("R9 set wins", d, 32'h6);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule